// File: doc/BRIEF.md
# Idle Depth Governor

This block picks how deep one logical CPU should sleep the next time it goes idle. Software or a sequencer pulses `idleStart` when the CPU stops issuing instructions and `idleEnd` when it resumes. The block times each idle interval against a free-running cycle counter. It then compares that length with two programmable exit latencies, one for the medium state and one for the deep state. From that comparison it recommends the shallow (C1), medium (C2) or deep (C3) state for the following idle period.

Moving deeper is deliberately slow. It takes an unbroken run of idles that each outlast the next level's exit latency, and the run length differs per level. Moving shallower is immediate: a single idle shorter than the current level's exit latency drops the recommendation by one level. The recommendation is registered and announced by a one-cycle valid pulse after every accepted idle end.

Top module: `idle_gov`

## Requirements
- R1: After reset, `nextState` reads 1 (C1), `nextValid` is 0, and the run of qualifying idles is empty.
- R2: `nextState` encodes C1 as 1, C2 as 2 and C3 as 3. After the clock edge that samples an accepted `idleEnd`, `nextValid` is 1 for exactly that one cycle, and `nextState` already holds the new choice. `nextState` changes at no other time.
- R3: Idle length is the number of clock edges from the edge that samples `idleStart` to the edge that samples `idleEnd`, which equals the advance of `cycleCount` between them. It saturates at 2^CNT_W-1 and does not wrap.
- R4: While at C1, once PROMO12 (default 4) consecutive idles are each strictly longer than `latC2`, the choice becomes C2.
- R5: While at C2, once PROMO23 (default 10) consecutive idles are each strictly longer than `latC3`, the choice becomes C3.
- R6: At C2, an idle strictly shorter than `latC2` gives C1. At C3, an idle strictly shorter than `latC3` gives C2.
- R7: The run of qualifying idles restarts from zero on any idle that fails the promotion test and on every promotion or demotion.
- R8: C1 never demotes and C3 never promotes. An idle exactly equal to a latency neither qualifies for promotion nor causes demotion.
- R9: `idleEnd` outside an idle period has no effect and gives no valid pulse. `idleStart` inside an idle period is ignored, so the length still runs from the first start.
- R10: `idleStart` and `idleEnd` in the same cycle during an idle period close the current period and open a new one whose length starts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idleStart | input | 1 | Pulse: the CPU has entered idle |
| idleEnd | input | 1 | Pulse: the CPU has left idle |
| cycleCount | input | CNT_W | Free-running cycle counter |
| latC2 | input | CNT_W | Exit latency of C2, in cycles |
| latC3 | input | CNT_W | Exit latency of C3, in cycles |
| nextState | output | 2 | Recommended state for the next idle (1, 2, 3) |
| nextValid | output | 1 | One-cycle pulse when `nextState` is refreshed |

## Verification
The two functions that can fall in the same cycle are closing one idle period, with its promote or demote decision, and opening the next one. The bench provokes this by pulsing both strobes together in the middle of an idle and chaining four such periods. It judges the result by whether the chained periods, each timed from the shared edge, earn a promotion. Three further cases are checked: a restart attempt inside an idle, which must not shorten the measured length; lengths exactly equal to a latency; and saturated lengths that would misjudge the latency if they wrapped. A behavioural model that counts elapsed cycles is compared with the outputs on every clock.

// File: rtl/idle_gov_pkg.sv
package idle_gov_pkg;

  typedef enum logic [1:0] {
    CS_C1 = 2'd1,
    CS_C2 = 2'd2,
    CS_C3 = 2'd3
  } cstate_e;

  // strobes from control to the length datapath
  typedef struct packed {
    logic arm;    // capture a new start stamp this edge
    logic track;  // an idle period is open
  } dp_ctl_t;

endpackage

// File: rtl/idle_gov_dp.sv
module idle_gov_dp
  import idle_gov_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dp_ctl_t          dpCtl,
  input  logic [CNT_W-1:0] cycleCount,
  output logic [CNT_W-1:0] idleLen
);

  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] startStamp;
  logic [CNT_W-1:0] prevDiff;
  logic [CNT_W-1:0] diffNow;
  logic             wrapped;
  logic             wrapNow;

  always_comb begin
    diffNow = cycleCount - startStamp;
    wrapNow = dpCtl.track && (diffNow < prevDiff);
    idleLen = (wrapped || wrapNow) ? LEN_MAX : diffNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startStamp <= '0;
      prevDiff   <= '0;
      wrapped    <= 1'b0;
    end else if (dpCtl.arm) begin
      startStamp <= cycleCount;
      prevDiff   <= '0;
      wrapped    <= 1'b0;
    end else if (dpCtl.track) begin
      prevDiff <= diffNow;
      if (wrapNow) wrapped <= 1'b1;
    end
  end

  // R3
  len_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |-> (idleLen == LEN_MAX));

  // R3
  len_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dpCtl.track) && !$past(dpCtl.arm) && dpCtl.track && !dpCtl.arm)
      |-> (idleLen >= $past(idleLen)));

endmodule

// File: rtl/idle_gov_ctl.sv
module idle_gov_ctl
  import idle_gov_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PROMO12 = 4,
  parameter int PROMO23 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idleStart,
  input  logic             idleEnd,
  input  logic [CNT_W-1:0] idleLen,
  input  logic [CNT_W-1:0] latC2,
  input  logic [CNT_W-1:0] latC3,
  output dp_ctl_t          dpCtl,
  output cstate_e          nextState,
  output logic             nextValid
);

  localparam int RUN_MAX = (PROMO12 > PROMO23) ? PROMO12 : PROMO23;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN12 = RUN_W'(PROMO12);
  localparam logic [RUN_W-1:0] RUN23 = RUN_W'(PROMO23);

  logic             inIdle;
  logic             finishIdle;
  logic             beginIdle;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runInc;
  logic [RUN_W-1:0] runNxt;
  cstate_e          stateNxt;

  always_comb begin
    finishIdle = idleEnd && inIdle;
    beginIdle  = idleStart && (!inIdle || idleEnd);
    dpCtl.arm   = beginIdle;
    dpCtl.track = inIdle;
  end

  always_comb begin
    runInc   = runCnt + 1'b1;
    stateNxt = nextState;
    runNxt   = runCnt;
    case (nextState)
      CS_C1: begin
        if (idleLen > latC2) begin
          if (runInc == RUN12) begin
            stateNxt = CS_C2;
            runNxt   = '0;
          end else begin
            runNxt = runInc;
          end
        end else begin
          runNxt = '0;
        end
      end
      CS_C2: begin
        if (idleLen < latC2) begin
          stateNxt = CS_C1;
          runNxt   = '0;
        end else if (idleLen > latC3) begin
          if (runInc == RUN23) begin
            stateNxt = CS_C3;
            runNxt   = '0;
          end else begin
            runNxt = runInc;
          end
        end else begin
          runNxt = '0;
        end
      end
      CS_C3: begin
        runNxt = '0;
        if (idleLen < latC3) stateNxt = CS_C2;
      end
      default: begin
        stateNxt = CS_C1;
        runNxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inIdle    <= 1'b0;
      runCnt    <= '0;
      nextState <= CS_C1;
      nextValid <= 1'b0;
    end else begin
      nextValid <= finishIdle;
      if (beginIdle)       inIdle <= 1'b1;
      else if (finishIdle) inIdle <= 1'b0;
      if (finishIdle) begin
        nextState <= stateNxt;
        runCnt    <= runNxt;
      end
    end
  end

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nextValid |-> ($past(idleEnd) && $past(inIdle)));

  // R2
  change_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nextState != $past(nextState)) |-> nextValid);

  // R6
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((nextState == CS_C3 && $past(nextState) == CS_C1) ||
      (nextState == CS_C1 && $past(nextState) == CS_C3)));

  // R4
  promo12_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nextState == CS_C2 && $past(nextState) == CS_C1)
      |-> ($past(runCnt) == RUN12 - 1'b1));

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runCnt < RUN23) && ((nextState != CS_C1) || (runCnt < RUN12)));

  // R7
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nextState != $past(nextState)) |-> (runCnt == '0));

endmodule

// File: rtl/idle_gov.sv
module idle_gov
  import idle_gov_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PROMO12 = 4,
  parameter int PROMO23 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idleStart,
  input  logic             idleEnd,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic [CNT_W-1:0] latC2,
  input  logic [CNT_W-1:0] latC3,
  output logic [1:0]       nextState,
  output logic             nextValid
);

  dp_ctl_t          dpCtl;
  logic [CNT_W-1:0] idleLen;
  cstate_e          stateQ;

  idle_gov_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .dpCtl      (dpCtl),
    .cycleCount (cycleCount),
    .idleLen    (idleLen)
  );

  idle_gov_ctl #(
    .CNT_W   (CNT_W),
    .PROMO12 (PROMO12),
    .PROMO23 (PROMO23)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .idleStart (idleStart),
    .idleEnd   (idleEnd),
    .idleLen   (idleLen),
    .latC2     (latC2),
    .latC3     (latC3),
    .dpCtl     (dpCtl),
    .nextState (stateQ),
    .nextValid (nextValid)
  );

  assign nextState = stateQ;

endmodule

// File: tb/idle_gov_bench.sv
module idle_gov_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam int LMAX       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         idleStart = 1'b0;
  logic         idleEnd = 1'b0;
  logic [W-1:0] cycleCount = '0;
  logic [W-1:0] latC2 = W'(20);
  logic [W-1:0] latC3 = W'(50);
  logic [1:0]   nextState;
  logic         nextValid;

  int    vecs = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // reference model state
  int mState = 1;
  int mValid = 0;
  int mRun = 0;
  int mIdle = 0;
  int mElapsed = 0;

  idle_gov #(.CNT_W(W)) u_idle_gov (
    .clk        (clk),
    .rst_n      (rst_n),
    .idleStart  (idleStart),
    .idleEnd    (idleEnd),
    .cycleCount (cycleCount),
    .latC2      (latC2),
    .latC3      (latC3),
    .nextState  (nextState),
    .nextValid  (nextValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) cycleCount <= cycleCount + 1'b1;

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 1; mValid = 0; mRun = 0; mIdle = 0; mElapsed = 0;
    end else begin
      int len;
      bit fin, beg;
      mValid = 0;
      if (mIdle != 0) mElapsed = mElapsed + 1;
      fin = idleEnd && (mIdle != 0);
      beg = idleStart && ((mIdle == 0) || idleEnd);
      if (fin) begin
        len = (mElapsed > LMAX) ? LMAX : mElapsed;
        mValid = 1;
        if (mState == 1) begin
          if (len > int'(latC2)) begin
            mRun = mRun + 1;
            if (mRun == 4) begin mState = 2; mRun = 0; end
          end else mRun = 0;
        end else if (mState == 2) begin
          if (len < int'(latC2)) begin mState = 1; mRun = 0; end
          else if (len > int'(latC3)) begin
            mRun = mRun + 1;
            if (mRun == 10) begin mState = 3; mRun = 0; end
          end else mRun = 0;
        end else begin
          if (len < int'(latC3)) mState = 2;
          mRun = 0;
        end
        mIdle = 0;
      end
      if (beg) begin
        mIdle = 1;
        mElapsed = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vecs++;
      if (int'(nextState) != mState || int'(nextValid) != mValid) begin
        fails++;
        $display("FAIL %s: state=%0d valid=%0d expected state=%0d valid=%0d",
                 curReq, nextState, nextValid, mState, mValid);
      end
    end
  end

  task automatic expectState(input int exp, input string req);
    vecs++;
    if (int'(nextState) != exp) begin
      fails++;
      $display("FAIL %s: directed state=%0d expected=%0d", req, nextState, exp);
    end
  endtask

  task automatic doIdle(input int len);
    idleStart = 1'b1;
    @(negedge clk) idleStart = 1'b0;
    repeat (len - 1) @(negedge clk);
    idleEnd = 1'b1;
    @(negedge clk) idleEnd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic doIdles(input int n, input int len);
    for (int i = 0; i < n; i++) doIdle(len);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL %s: watchdog expired", curReq);
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    curReq = "R1";
    vecs++;
    if (nextState !== 2'd1 || nextValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: state=%0d valid=%0d expected 1/0", nextState, nextValid);
    end

    // R4 / R7: broken run in C1, then full run
    curReq = "R7";
    doIdles(3, 30);
    doIdle(10);
    expectState(1, "R7");
    doIdles(3, 30);
    expectState(1, "R4");
    curReq = "R4";
    doIdle(30);
    expectState(2, "R4");

    // R8: equal to latC2 in C2 neither demotes
    curReq = "R8";
    doIdle(20);
    expectState(2, "R8");

    // R5 / R7: runs broken by a middling idle and by an equal one
    curReq = "R7";
    doIdles(9, 60);
    doIdle(30);
    expectState(2, "R7");
    doIdles(9, 60);
    doIdle(50);
    expectState(2, "R8");
    curReq = "R5";
    doIdles(9, 60);
    expectState(2, "R5");
    doIdle(60);
    expectState(3, "R5");

    // R8: C3 stays on long idles
    curReq = "R8";
    doIdles(3, 200);
    expectState(3, "R8");

    // R6: demotions
    curReq = "R6";
    doIdle(40);
    expectState(2, "R6");
    doIdle(10);
    expectState(1, "R6");
    curReq = "R8";
    doIdle(5);
    expectState(1, "R8");

    // R9: stray end, then restart attempt inside an idle
    curReq = "R9";
    idleEnd = 1'b1;
    @(negedge clk) idleEnd = 1'b0;
    vecs++;
    if (nextValid !== 1'b0) begin
      fails++;
      $display("FAIL R9: valid=%0d expected=0 after stray end", nextValid);
    end
    doIdles(3, 30);
    idleStart = 1'b1;
    @(negedge clk) idleStart = 1'b0;
    repeat (14) @(negedge clk);
    idleStart = 1'b1;
    @(negedge clk) idleStart = 1'b0;
    repeat (9) @(negedge clk);
    idleEnd = 1'b1;
    @(negedge clk) idleEnd = 1'b0;
    repeat (3) @(negedge clk);
    expectState(2, "R9");
    doIdle(10);
    expectState(1, "R6");

    // R10: chained periods sharing start/end edges
    curReq = "R10";
    idleStart = 1'b1;
    @(negedge clk) idleStart = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (29) @(negedge clk);
      idleEnd = 1'b1;
      idleStart = (k < 3);
      @(negedge clk);
      idleEnd = 1'b0;
      idleStart = 1'b0;
    end
    repeat (3) @(negedge clk);
    expectState(2, "R10");
    doIdle(10);
    expectState(1, "R10");

    // R3: saturated lengths
    curReq = "R3";
    latC2 = W'(LMAX - 1);
    latC3 = W'(LMAX);
    doIdles(4, 1500);
    expectState(2, "R3");
    latC2 = W'(LMAX);
    doIdle(1500);
    expectState(2, "R3");

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule